// File: doc/BRIEF.md
# UART Modem Control and Local Loopback

This block holds the modem control register of one UART channel and routes the channel's serial and modem signals between the device pins and the channel's internal logic. A host writes the register through a simple strobed write port and reads it back at any time. Its five bits drive the active-low modem outputs, control whether the channel's interrupt pin may assert, and select a local loopback mode used for diagnostics.

In normal operation the transmitter's serial output goes to the pin and the pin inputs reach the receiver and the modem status logic. The status inputs arrive at the pins active low and are handed on active high, so a high status output means the line is asserted. In loopback the pins are driven inactive and the external inputs are disconnected. The transmitter output is turned back onto the receiver. The four modem control bits stand in for the four modem status lines. The interrupt enable is shaped by the bus mode, and the interrupt output is given as an enable plus a value, not as a true tristate.

Top module: `modem_ctrl`

## Requirements
- R1: After reset all register bits are 0: readback is 0x00, and dtr_no, rts_no, out1_no and out2_no are all 1.
- R2: A cycle with wr_en_i high stores wr_data_i[4:0] in the register at that clock edge (bit 0 DTR, 1 RTS, 2 OUT1, 3 OUT2, 4 loopback). rd_data_o returns the stored bits, and bits 7:5 always read 0. Without wr_en_i the register holds its value.
- R3: With loopback off, dtr_no equals the inverse of bit 0 and rts_no equals the inverse of bit 1.
- R4: With loopback off, out1_no equals the inverse of bit 2 and out2_no equals the inverse of bit 3.
- R5: With loopback off, sout_o follows tx_i and rx_o follows sin_i. cts_o, dsr_o, dcd_o and ri_o are the inverses of cts_ni, dsr_ni, dcd_ni and ri_ni.
- R6: With loopback on (bit 4 = 1), sout_o, dtr_no, rts_no, out1_no and out2_no are all 1.
- R7: With loopback on, rx_o follows tx_i, dsr_o equals bit 0, cts_o equals bit 1, ri_o equals bit 2 and dcd_o equals bit 3. sin_i and the four status pins have no effect.
- R8: In Intel bus mode (intel_mode_i = 1) with int_sel_ni = 0, irq_oe_o equals bit 3.
- R9: When intel_mode_i = 0, or when int_sel_ni = 1, irq_oe_o is 1.
- R10: irq_o is high only when both irq_oe_o and irq_req_i are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register readback |
| intel_mode_i | input | 1 | 1 = Intel bus mode, 0 = other bus mode |
| int_sel_ni | input | 1 | Interrupt select pin, active low |
| irq_req_i | input | 1 | Internal interrupt request |
| irq_oe_o | output | 1 | Interrupt pin output enable |
| irq_o | output | 1 | Interrupt pin value |
| tx_i | input | 1 | Transmitter serial output (internal) |
| sout_o | output | 1 | Serial output pin |
| sin_i | input | 1 | Serial input pin |
| rx_o | output | 1 | Receiver serial input (internal) |
| cts_ni | input | 1 | Clear-to-send pin, active low |
| dsr_ni | input | 1 | Data-set-ready pin, active low |
| dcd_ni | input | 1 | Carrier-detect pin, active low |
| ri_ni | input | 1 | Ring-indicator pin, active low |
| cts_o | output | 1 | Clear-to-send status, active high |
| dsr_o | output | 1 | Data-set-ready status, active high |
| dcd_o | output | 1 | Carrier-detect status, active high |
| ri_o | output | 1 | Ring-indicator status, active high |
| dtr_no | output | 1 | Data-terminal-ready pin, active low |
| rts_no | output | 1 | Request-to-send pin, active low |
| out1_no | output | 1 | User output 1 pin, active low |
| out2_no | output | 1 | User output 2 pin, active low |

## Verification
The bench writes random register values, including bits 7:5, while it toggles the serial and status pins at random and sweeps the four combinations of bus mode and interrupt select. In loopback the pins are moved while the register is held, which separates a design that truly disconnects the pins from one that merely mirrors them. Each status output is compared with its own control bit, so a swapped cross-connection (DTR to CTS instead of DSR, for example) fails. The interrupt enable is checked separately in Intel mode and in the other bus mode, which tells apart gating that wrongly ignores the bus mode from gating that wrongly ignores the select pin.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned MCR_W  = 5;

  // bit order is the register layout
  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mcr_t;
endpackage

// File: rtl/mcr_reg.sv
module mcr_reg
  import modem_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output mcr_t          mcr_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned PAD_W = DW - MCR_W;

  mcr_t mcr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mcr_q <= '0;
    else if (wr_en_i) mcr_q <= mcr_t'(wr_data_i[MCR_W-1:0]);
  end

  assign mcr_o     = mcr_q;
  assign rd_data_o = {{PAD_W{1'b0}}, mcr_q};

  a_r2_write_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == {{PAD_W{1'b0}}, $past(wr_data_i[MCR_W-1:0])});
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/loop_route.sv
module loop_route
  import modem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  mcr_t mcr_i,
  input  logic tx_i,
  output logic sout_o,
  input  logic sin_i,
  output logic rx_o,
  input  logic cts_ni,
  input  logic dsr_ni,
  input  logic dcd_ni,
  input  logic ri_ni,
  output logic cts_o,
  output logic dsr_o,
  output logic dcd_o,
  output logic ri_o,
  output logic dtr_no,
  output logic rts_no,
  output logic out1_no,
  output logic out2_no
);
  always_comb begin
    if (mcr_i.loop) begin
      sout_o  = 1'b1;
      dtr_no  = 1'b1;
      rts_no  = 1'b1;
      out1_no = 1'b1;
      out2_no = 1'b1;
      rx_o    = tx_i;
      // outputs cross onto status lines
      dsr_o   = mcr_i.dtr;
      cts_o   = mcr_i.rts;
      ri_o    = mcr_i.out1;
      dcd_o   = mcr_i.out2;
    end else begin
      sout_o  = tx_i;
      dtr_no  = ~mcr_i.dtr;
      rts_no  = ~mcr_i.rts;
      out1_no = ~mcr_i.out1;
      out2_no = ~mcr_i.out2;
      rx_o    = sin_i;
      dsr_o   = ~dsr_ni;
      cts_o   = ~cts_ni;
      ri_o    = ~ri_ni;
      dcd_o   = ~dcd_ni;
    end
  end

  a_r6_pins_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_i.loop |-> (sout_o && dtr_no && rts_no && out1_no && out2_no));
  a_r7_rx_loop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_i.loop |-> rx_o == tx_i);
  a_r7_status_cross: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_i.loop |-> (dsr_o == mcr_i.dtr && cts_o == mcr_i.rts &&
                    ri_o == mcr_i.out1 && dcd_o == mcr_i.out2));
  a_r5_pins_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mcr_i.loop |-> (sout_o == tx_i && rx_o == sin_i && cts_o != cts_ni));
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic intel_mode_i,
  input  logic int_sel_ni,
  input  logic out2_i,
  input  logic irq_req_i,
  output logic irq_oe_o,
  output logic irq_o
);
  logic gated;
  assign gated    = intel_mode_i & ~int_sel_ni;
  assign irq_oe_o = ~gated | out2_i;
  assign irq_o    = irq_oe_o & irq_req_i;

  a_r8_gated_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intel_mode_i && !int_sel_ni && !out2_i) |-> !irq_oe_o);
  a_r9_always_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!intel_mode_i || int_sel_ni) |-> irq_oe_o);
  a_r10_no_float_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_oe_o && irq_req_i));
endmodule

// File: rtl/modem_ctrl.sv
module modem_ctrl
  import modem_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          intel_mode_i,
  input  logic          int_sel_ni,
  input  logic          irq_req_i,
  output logic          irq_oe_o,
  output logic          irq_o,
  input  logic          tx_i,
  output logic          sout_o,
  input  logic          sin_i,
  output logic          rx_o,
  input  logic          cts_ni,
  input  logic          dsr_ni,
  input  logic          dcd_ni,
  input  logic          ri_ni,
  output logic          cts_o,
  output logic          dsr_o,
  output logic          dcd_o,
  output logic          ri_o,
  output logic          dtr_no,
  output logic          rts_no,
  output logic          out1_no,
  output logic          out2_no
);
  mcr_t mcr;

  mcr_reg #(.DW(DW)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .mcr_o(mcr), .rd_data_o
  );

  loop_route u_route (
    .clk_i, .rst_ni, .mcr_i(mcr),
    .tx_i, .sout_o, .sin_i, .rx_o,
    .cts_ni, .dsr_ni, .dcd_ni, .ri_ni,
    .cts_o, .dsr_o, .dcd_o, .ri_o,
    .dtr_no, .rts_no, .out1_no, .out2_no
  );

  irq_gate u_irq (
    .clk_i, .rst_ni, .intel_mode_i, .int_sel_ni,
    .out2_i(mcr.out2), .irq_req_i, .irq_oe_o, .irq_o
  );

  a_r1_reset_idle: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (rd_data_o == '0 && dtr_no && rts_no));
endmodule

// File: tb/modem_ctrl_tb.sv
module modem_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic intel_mode = 1'b0, int_sel_n = 1'b1, irq_req = 1'b0;
  logic irq_oe, irq;
  logic tx = 1'b1, sout, sin = 1'b1, rx;
  logic cts_n = 1'b1, dsr_n = 1'b1, dcd_n = 1'b1, ri_n = 1'b1;
  logic cts, dsr, dcd, ri, dtr_n, rts_n, out1_n, out2_n;

  int checks = 0;
  int errors = 0;
  logic [4:0] model = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .intel_mode_i(intel_mode), .int_sel_ni(int_sel_n),
    .irq_req_i(irq_req), .irq_oe_o(irq_oe), .irq_o(irq),
    .tx_i(tx), .sout_o(sout), .sin_i(sin), .rx_o(rx),
    .cts_ni(cts_n), .dsr_ni(dsr_n), .dcd_ni(dcd_n), .ri_ni(ri_n),
    .cts_o(cts), .dsr_o(dsr), .dcd_o(dcd), .ri_o(ri),
    .dtr_no(dtr_n), .rts_no(rts_n), .out1_no(out1_n), .out2_no(out2_n)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {sout,dtr_n,rts_n,out1_n,out2_n}
  function automatic logic [4:0] exp_pins(logic [4:0] m, logic t);
    if (m[4]) return 5'b11111;
    return {t, ~m[0], ~m[1], ~m[2], ~m[3]};
  endfunction

  // {rx,dsr,cts,ri,dcd}
  function automatic logic [4:0] exp_stat(logic [4:0] m, logic t, logic s,
                                          logic dsrn, logic ctsn, logic rin, logic dcdn);
    if (m[4]) return {t, m[0], m[1], m[2], m[3]};
    return {s, ~dsrn, ~ctsn, ~rin, ~dcdn};
  endfunction

  // {oe, irq}
  function automatic logic [1:0] exp_irq(logic [4:0] m, logic im, logic isn, logic rq);
    logic oe;
    oe = (im && !isn) ? m[3] : 1'b1;
    return {oe, oe & rq};
  endfunction

  task automatic check_all();
    logic [4:0] p, s;
    logic [1:0] q;
    p = exp_pins(model, tx);
    s = exp_stat(model, tx, sin, dsr_n, cts_n, ri_n, dcd_n);
    q = exp_irq(model, intel_mode, int_sel_n, irq_req);
    check("R2 readback", rd_data, {3'b000, model});
    if (model[4]) begin
      check("R6 loop pins", {3'b0, sout, dtr_n, rts_n, out1_n, out2_n}, {3'b0, p});
      check("R7 loop status", {3'b0, rx, dsr, cts, ri, dcd}, {3'b0, s});
    end else begin
      check("R3 dtr/rts", {6'b0, dtr_n, rts_n}, {6'b0, p[3:2]});
      check("R4 out1/out2", {6'b0, out1_n, out2_n}, {6'b0, p[1:0]});
      check("R5 pass-through", {2'b0, sout, rx, dsr, cts, ri, dcd}, {2'b0, p[4], s});
    end
    if (intel_mode && !int_sel_n)
      check("R8 gated oe", {7'b0, irq_oe}, {7'b0, q[1]});
    else
      check("R9 oe forced", {7'b0, irq_oe}, {7'b0, q[1]});
    check("R10 irq value", {7'b0, irq}, {7'b0, q[0]});
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    check_all();
    @(negedge clk);
  endtask

  task automatic rand_pins();
    {tx, sin, cts_n, dsr_n, dcd_n, ri_n, irq_req} = 7'($urandom);
    {intel_mode, int_sel_n} = 2'($urandom);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #(3*CLK_PERIOD);
    // R1: reset state
    check("R1 readback", rd_data, 8'h00);
    check("R1 outputs", {4'b0, dtr_n, rts_n, out1_n, out2_n}, 8'h0f);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R2 directed: upper bits dropped
    wr_en = 1'b1; wr_data = 8'hEF; model = 5'h0F;
    step();
    wr_en = 1'b0; wr_data = 8'h10;
    step();
    check("R2 hold", rd_data, 8'h0F);

    // R7 directed: loopback with pins toggled, register held
    wr_en = 1'b1; wr_data = 8'h15; model = 5'h15;
    step();
    wr_en = 1'b0;
    for (int i = 0; i < 16; i++) begin
      {sin, cts_n, dsr_n, dcd_n, ri_n} = 5'(i * 7);
      tx = i[0];
      #1;
      check("R7 pins ignored", {3'b0, rx, dsr, cts, ri, dcd}, {3'b0, tx, 4'b1010});
      @(negedge clk);
    end

    // R8/R9 directed sweep of modes with OUT2 clear and set
    for (int o = 0; o < 2; o++) begin
      wr_en = 1'b1; wr_data = {4'b0, o[0], 3'b0}; model = {1'b0, o[0], 3'b0};
      step();
      wr_en = 1'b0;
      for (int m = 0; m < 4; m++) begin
        {intel_mode, int_sel_n} = m[1:0];
        irq_req = 1'b1;
        step();
      end
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      rand_pins();
      wr_en = ($urandom % 3) == 0;
      wr_data = 8'($urandom);
      if (wr_en) model = wr_data[4:0];
      step();
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(150000 * CLK_PERIOD);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule